// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block sits beside an SDRAM command sequencer and produces the column address for every beat of a read or write burst. A mode word arrives on a 14-bit address bus together with a mode-set strobe. The block checks the word and stores its burst length, address ordering, CAS latency and write policy. An illegal word raises an error flag, and the block keeps the mode it already holds.

A start strobe launches a burst from a given column. The block then presents one column per clock and marks the final beat. Read bursts always use the programmed length. Writes can be restricted to one beat while reads still burst. Interleaved ordering is supported. A full-page sequential burst walks the whole page and wraps at its end, and it runs until a terminate strobe ends it. A new start strobe given during a burst abandons the old burst and begins the new one at once.

Top module: `sdram_burst_colseq`

## Requirements
- R1: After reset no beat is valid, the error flag is low, the reported latency is 2, and the mode is burst length 1, sequential, with writes bursting.
- R2: On a mode-set cycle the word is split into these fields: bits 2..0 length code (000=1, 001=2, 010=4, 011=8, 111=full page), bit 3 ordering (0 sequential, 1 interleaved), bits 6..4 latency code (010=2, 011=3), bit 7 test request, and bits 13..8 write policy (000000 = writes burst, 000010 = writes single). A legal word takes effect from the next cycle, and the latency output follows it from that cycle.
- R3: A word is illegal if its length code is 100, 101 or 110, if it has length code 111 with bit 3 set, if its latency code is anything other than 010 or 011, if bit 7 is high, or if its policy bits hold any value except 000000 or 000010. An illegal word sets the error flag from the next cycle and leaves the stored mode unchanged. The next legal word clears the flag.
- R4: A start strobe makes the beat-valid output high in the next cycle, with the starting column on the column output. One beat follows each cycle after that.
- R5: A sequential burst of length N steps only the low log2(N) column bits and wraps inside the aligned N-column block.
- R6: An interleaved burst presents the starting column XOR the beat index on the low log2(N) bits.
- R7: The last-beat flag is high only on beat N-1 of a fixed-length burst. Beat-valid drops in the following cycle unless a new start arrives.
- R8: When writes are single, a write burst is one beat long and is marked last. Read bursts keep the full length.
- R9: A full-page burst adds one to the 9-bit column each cycle, passes from 511 to 0, and never raises the last-beat flag.
- R10: A terminate strobe given without a start ends the burst, so beat-valid is low in the next cycle.
- R11: A start strobe during a burst abandons that burst and begins the new one from its starting column in the next cycle. Start takes priority over terminate.
- R12: A burst keeps the length and ordering that were in force when it started, even if a mode-set occurs while it runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_set_i | input | 1 | Mode-set strobe |
| mode_addr_i | input | 14 | Mode word |
| start_i | input | 1 | Burst start strobe |
| start_write_i | input | 1 | High when the starting burst is a write |
| start_col_i | input | 9 | Starting column |
| stop_i | input | 1 | Terminate strobe |
| col_o | output | 9 | Column of the current beat |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| last_beat_o | output | 1 | Current beat is the final one |
| cas_lat_o | output | 2 | Decoded CAS latency (2 or 3) |
| mode_err_o | output | 1 | Last mode word was illegal |

## Verification
The wrap of a full-page burst from column 511 back to 0 is reached only after a long run. To get there quickly, the stimulus starts a full-page burst a few columns below the page end, lets it run past the wrap, and then ends it with the terminate strobe. The stimulus shows that a rejected mode word left the old mode in place by starting a burst right after each illegal word: the old length and ordering must still appear. The stimulus also issues a restart and a mode-set while a burst is running, which places those commands in mid-burst.

// File: rtl/sdram_cs_pkg.sv
package sdram_cs_pkg;

    localparam int MODE_W = 14;

    typedef struct packed {
        logic [2:0] len_code;
        logic       interleave;
        logic       lat3;
        logic       single_wr;
    } mode_t;

    localparam mode_t MODE_RESET = '{len_code: 3'b000, interleave: 1'b0,
                                     lat3: 1'b0, single_wr: 1'b0};

    function automatic logic word_legal(input logic [MODE_W-1:0] w);
        logic len_ok, lat_ok, op_ok;
        len_ok = (w[2] == 1'b0) || (w[2:0] == 3'b111 && w[3] == 1'b0);
        lat_ok = (w[6:4] == 3'b010) || (w[6:4] == 3'b011);
        op_ok  = (w[13:10] == 4'b0000) && (w[8] == 1'b0);
        return len_ok && lat_ok && op_ok && (w[7] == 1'b0);
    endfunction

endpackage

// File: rtl/sdram_cs_mode_reg.sv
module sdram_cs_mode_reg
    import sdram_cs_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              set_i,
    input  logic [MODE_W-1:0] word_i,
    output mode_t             mode_o,
    output logic              err_o
);

    typedef struct packed {
        mode_t mode;
        logic  err;
    } mstate_t;

    mstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            if (word_legal(word_i)) begin
                st_d.mode.len_code   = word_i[2:0];
                st_d.mode.interleave = word_i[3];
                st_d.mode.lat3       = word_i[4];
                st_d.mode.single_wr  = word_i[9];
                st_d.err             = 1'b0;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.mode <= MODE_RESET;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign err_o  = st_q.err;

endmodule

// File: rtl/sdram_cs_burst_ctl.sv
module sdram_cs_burst_ctl
    import sdram_cs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             write_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             stop_i,
    input  mode_t            mode_i,
    output logic             active_o,
    output logic             inter_o,
    output logic [COL_W-1:0] mask_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] cnt_o,
    output logic             last_o
);

    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    typedef struct packed {
        logic             active;
        logic             full;
        logic             inter;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] cnt;
    } bstate_t;

    bstate_t st_d, st_q;
    logic [COL_W-1:0] len_mask;
    logic             is_full, is_single, at_end;

    always_comb begin
        len_mask = '0;
        for (int i = 0; i < 3; i++) begin
            if (i < int'(mode_i.len_code[1:0])) len_mask[i] = 1'b1;
        end
    end

    assign is_full   = (mode_i.len_code == 3'b111);
    assign is_single = write_i && mode_i.single_wr;
    assign at_end    = st_q.active && !st_q.full && (st_q.cnt == st_q.mask);

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.base   = col_i;
            st_d.cnt    = '0;
            st_d.inter  = mode_i.interleave;
            if (is_single) begin
                st_d.full = 1'b0;
                st_d.mask = '0;
            end else if (is_full) begin
                st_d.full = 1'b1;
                st_d.mask = '1;
            end else begin
                st_d.full = 1'b0;
                st_d.mask = len_mask;
            end
        end else if (st_q.active) begin
            if (stop_i || at_end) begin
                st_d.active = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign inter_o  = st_q.inter;
    assign mask_o   = st_q.mask;
    assign base_o   = st_q.base;
    assign cnt_o    = st_q.cnt;
    assign last_o   = at_end;

endmodule

// File: rtl/sdram_cs_col_gen.sv
module sdram_cs_col_gen #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] cnt_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             inter_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] sum;

    assign sum = base_i + cnt_i;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        always_comb begin
            if (!mask_i[b])   col_o[b] = base_i[b];
            else if (inter_i) col_o[b] = base_i[b] ^ cnt_i[b];
            else              col_o[b] = sum[b];
        end
    end

endmodule

// File: rtl/sdram_burst_colseq.sv
module sdram_burst_colseq
    import sdram_cs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mode_set_i,
    input  logic [MODE_W-1:0] mode_addr_i,
    input  logic              start_i,
    input  logic              start_write_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic              stop_i,
    output logic [COL_W-1:0]  col_o,
    output logic              beat_valid_o,
    output logic              last_beat_o,
    output logic [1:0]        cas_lat_o,
    output logic              mode_err_o
);

    mode_t            mode;
    logic             inter;
    logic [COL_W-1:0] mask, base, cnt;

    sdram_cs_mode_reg u_mode (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (mode_set_i),
        .word_i (mode_addr_i),
        .mode_o (mode),
        .err_o  (mode_err_o)
    );

    sdram_cs_burst_ctl #(.COL_W(COL_W)) u_ctl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start_i),
        .write_i  (start_write_i),
        .col_i    (start_col_i),
        .stop_i   (stop_i),
        .mode_i   (mode),
        .active_o (beat_valid_o),
        .inter_o  (inter),
        .mask_o   (mask),
        .base_o   (base),
        .cnt_o    (cnt),
        .last_o   (last_beat_o)
    );

    sdram_cs_col_gen #(.COL_W(COL_W)) u_col (
        .base_i  (base),
        .cnt_i   (cnt),
        .mask_i  (mask),
        .inter_i (inter),
        .col_o   (col_o)
    );

    assign cas_lat_o = mode.lat3 ? 2'd3 : 2'd2;

endmodule

// File: rtl/sdram_cs_checker.sv
module sdram_cs_checker #(
    parameter int COL_W = 9
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             mode_set_i,
    input logic [13:0]      mode_addr_i,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             beat_valid_o,
    input logic             last_beat_o,
    input logic [1:0]       cas_lat_o,
    input logic             mode_err_o
);

    a_r4_start_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> beat_valid_o && (col_o == $past(start_col_i)));

    a_r10_stop_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_i && !start_i) |=> !beat_valid_o);

    a_r7_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (last_beat_o && !start_i) |=> !beat_valid_o);

    a_r7_last_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last_beat_o |-> beat_valid_o);

    a_r4_beats_continue: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (beat_valid_o && !last_beat_o && !stop_i) |=> beat_valid_o);

    a_r2_lat_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cas_lat_o == 2'd2) || (cas_lat_o == 2'd3));

    a_r3_test_bit_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_set_i && mode_addr_i[7]) |=> mode_err_o && (cas_lat_o == $past(cas_lat_o)));

endmodule

bind sdram_burst_colseq sdram_cs_checker #(.COL_W(COL_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_set_i   (mode_set_i),
    .mode_addr_i  (mode_addr_i),
    .start_i      (start_i),
    .start_col_i  (start_col_i),
    .stop_i       (stop_i),
    .col_o        (col_o),
    .beat_valid_o (beat_valid_o),
    .last_beat_o  (last_beat_o),
    .cas_lat_o    (cas_lat_o),
    .mode_err_o   (mode_err_o)
);

// File: tb/tb_sdram_burst_colseq.sv
`timescale 1ns/1ps
module tb_sdram_burst_colseq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_set = 1'b0;
    logic [13:0] mode_addr = '0;
    logic        start = 1'b0;
    logic        start_wr = 1'b0;
    logic [8:0]  start_col = '0;
    logic        stop = 1'b0;
    logic [8:0]  col;
    logic        valid, last, err;
    logic [1:0]  lat;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    string req = "R1";

    always #10 clk = ~clk;

    sdram_burst_colseq dut (
        .clk_i(clk), .rst_ni(rst_n), .mode_set_i(mode_set), .mode_addr_i(mode_addr),
        .start_i(start), .start_write_i(start_wr), .start_col_i(start_col), .stop_i(stop),
        .col_o(col), .beat_valid_o(valid), .last_beat_o(last), .cas_lat_o(lat),
        .mode_err_o(err)
    );

    // reference model
    int m_len, m_lat;
    bit m_full, m_inter, m_single, m_err;
    bit b_act, b_full, b_inter;
    int b_start, b_cnt, b_len;

    function automatic bit legal(input logic [13:0] w);
        bit ok = 1;
        if (w[2:0] inside {3'd4, 3'd5, 3'd6}) ok = 0;
        if (w[2:0] == 3'd7 && w[3]) ok = 0;
        if (!(w[6:4] inside {3'd2, 3'd3})) ok = 0;
        if (w[7]) ok = 0;
        if (!(w[13:8] inside {6'd0, 6'd2})) ok = 0;
        return ok;
    endfunction

    function automatic int exp_col();
        int off;
        if (b_full) return (b_start + b_cnt) % 512;
        off = b_start % b_len;
        if (b_inter) return (b_start - off) + (off ^ b_cnt);
        return (b_start - off) + ((off + b_cnt) % b_len);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_len = 1; m_full = 0; m_inter = 0; m_lat = 2; m_single = 0; m_err = 0;
            b_act = 0; b_full = 0; b_inter = 0; b_start = 0; b_cnt = 0; b_len = 1;
        end else begin
            if (start) begin
                b_act = 1; b_start = start_col; b_cnt = 0; b_inter = m_inter;
                if (start_wr && m_single) begin b_len = 1; b_full = 0; end
                else begin b_len = m_len; b_full = m_full; end
            end else if (b_act) begin
                if (stop || (!b_full && b_cnt == b_len - 1)) b_act = 0;
                else b_cnt = (b_cnt + 1) % 512;
            end
            if (mode_set) begin
                if (legal(mode_addr)) begin
                    m_full = (mode_addr[2:0] == 3'd7);
                    m_len = m_full ? 512 : (1 << mode_addr[1:0]);
                    m_inter = mode_addr[3];
                    m_lat = mode_addr[4] ? 3 : 2;
                    m_single = mode_addr[9];
                    m_err = 0;
                end else m_err = 1;
            end
        end
    end

    task automatic check();
        bit e_last;
        int e_col;
        e_last = b_act && !b_full && (b_cnt == b_len - 1);
        e_col = b_act ? exp_col() : 0;
        n_checks++;
        if (valid !== b_act || last !== e_last || err !== m_err || int'(lat) != m_lat ||
            (b_act && int'(col) != e_col)) begin
            n_fail++;
            $display("FAIL %s: valid=%0b last=%0b err=%0b lat=%0d col=%0d exp valid=%0b last=%0b err=%0b lat=%0d col=%0d",
                     req, valid, last, err, lat, col, b_act, e_last, m_err, m_lat, e_col);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cycles++;
        check();
        mode_set = 0; start = 0; stop = 0; start_wr = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic set_mode(input logic [13:0] w);
        mode_set = 1; mode_addr = w; tick();
    endtask

    task automatic go(input int c, input bit wr);
        start = 1; start_col = 9'(c); start_wr = wr; tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        req = "R1"; check();                         // reset state
        go(5, 0); idle(2);                           // R1 default length 1
        req = "R2"; set_mode(14'h032); idle(1);      // len4 seq lat3
        req = "R5"; go(13, 0); idle(5);              // 13,14,15,12
        req = "R7"; go(8, 1); idle(5);
        req = "R6"; set_mode(14'h03B); go(21, 0); idle(9);
        req = "R6"; set_mode(14'h039); go(6, 0); idle(3);
        req = "R3";
        set_mode(14'h0B2); go(3, 0); idle(3);        // test bit
        set_mode(14'h034); go(3, 0); idle(3);        // len code 100
        set_mode(14'h03F); go(3, 0); idle(3);        // full page interleaved
        set_mode(14'h01A); go(3, 0); idle(3);        // latency 001
        set_mode(14'h132); go(3, 0); idle(3);        // policy 01
        set_mode(14'h2032); idle(1);                 // high policy bit
        req = "R8"; set_mode(14'h222); idle(1);
        go(9, 1); idle(2); go(9, 0); idle(5);
        req = "R9"; set_mode(14'h027); go(508, 0); idle(8);
        req = "R10"; stop = 1; tick(); idle(2);
        req = "R9"; go(510, 1); idle(3);
        req = "R10"; stop = 1; tick(); idle(1);
        req = "R11"; set_mode(14'h023); go(3, 0); idle(2); go(64, 0); idle(9);
        req = "R11"; go(1, 0); start = 1; stop = 1; start_col = 9'd40; tick(); idle(9);
        req = "R12"; go(17, 0); idle(1); set_mode(14'h039); idle(8); go(17, 0); idle(3);
        req = "R5"; set_mode(14'h021); go(511, 0); idle(3);
        finish_run();
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

endmodule